// File: doc/BRIEF.md
# Oversampled SPI Register Slave with Sample FIFO

This block is an SPI target that lives entirely in the system clock domain. The serial clock, chip select and MOSI pins are treated as plain data. They pass through a two-stage synchronizer, and serial clock edges are found by comparing successive samples. Because of this, nothing in the block needs the serial clock to keep running once a transfer is over. The system clock must run at least four to five times faster than the serial clock.

Each transfer has three parts, sent in SPI mode 0 with the most significant bit first:

- A command byte. Bit 7 set to 1 means read and 0 means write. Bits 6:0 give the register address.
- A fixed number of dummy clock cycles. During this time the target fetches the value it will return.
- The data phase.

The block holds a small bank of 8-bit control registers. Register 0 is the fill threshold. One read-only address returns a 24-bit word made from the head of a 16-bit sample FIFO. Reading that word pops the FIFO.

The data_ready output is meant for a host interrupt pin. It is high while the FIFO level is at or above the threshold.

Top module: `oss_spi_regs`

## Requirements
- R1: After reset, MISO and data_ready are low and the FIFO is empty. Register 0 (the threshold) reads FIFO_DEPTH/2, which is 8 by default. Registers 1..NUM_REGS-1 read 0.
- R2: A write has three parts: a command byte with bit 7 = 0 and address in bits 6:0, then DUMMY (default 4) don't-care clock cycles, then 8 data bits MSB first. The byte is stored when its eighth bit is sampled on a rising edge. Any later bits are ignored.
- R3: A read uses a command byte with bit 7 = 1, then DUMMY cycles. The target then drives the register byte MSB first. Each bit changes after a falling edge and is valid at the next rising edge. Reading a control register changes nothing.
- R4: A read of FIFO_ADDR (0x10) returns 24 bits, laid out as follows. Bit 23 is the valid flag. Bits 22:16 are zero. Bits 15:0 hold the oldest sample. The FIFO pops exactly once per read, at the last dummy rising edge, and samples come out in arrival order.
- R5: A read of FIFO_ADDR while the FIFO is empty returns all zeros (valid = 0) and does not change the FIFO.
- R6: A sample is pushed when adc_valid is high on a clock edge and the FIFO holds fewer than FIFO_DEPTH (16) entries. Samples offered while the FIFO is full are dropped.
- R7: data_ready equals (FIFO level >= register 0), compared as unsigned. It follows a push or pop on the same clock edge that changes the level.
- R8: Raising chip select ends a transfer at once. A write cut off before its eighth data bit stores nothing. A read cut off before the end of the dummy phase does not pop. The next transfer decodes normally.
- R9: MISO is held low while chip select is high.
- R10: Writes to addresses at or above NUM_REGS, including FIFO_ADDR, are ignored. Reads of unmapped addresses return zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4-5x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, low when deselected |
| adc_valid | input | 1 | Push strobe for one sample |
| adc_sample | input | SAMPLE_W (16) | Sample word to queue |
| data_ready | output | 1 | FIFO level has reached the threshold |

## Verification
Every pin change on the serial side takes effect three system clocks later: two synchronizer stages plus the register that acts on the detected edge. The bench therefore holds each serial clock level for five system clocks. It reads MISO on the host's rising edge, by which time the bit driven after the previous falling edge has settled. A push or pop moves data_ready on the same edge that changes the FIFO level. A behavioural model holds the FIFO as a queue and the registers as an array. It is compared against data_ready and MISO at every falling system clock edge while no transfer is in flight. Each transfer's returned word is checked when chip select rises.

// File: rtl/oss_pkg.sv
// Shared types for the oversampled SPI register slave.
package oss_pkg;
    // Phase of the serial transfer.
    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_DUMMY = 2'd1,
        PH_DATA  = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;
endpackage

// File: rtl/oss_pin_sync.sv
// Brings the serial pins into the system clock domain and finds serial
// clock edges from successive samples.
// Assumes the system clock is at least 4x the serial clock, so that each
// serial clock level is seen on at least two system clock edges.
module oss_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic mosi_pin,
    input  logic cs_n_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_idle
);
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic              sclk_last;

    // Shift each pin through its synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            mosi_pipe <= '0;
            cs_pipe   <= '1;
            sclk_last <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_pin};
            mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_pin};
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n_pin};
            sclk_last <= sclk_pipe[STAGES-1];
        end
    end

    assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_last;
    assign sclk_fall = ~sclk_pipe[STAGES-1] & sclk_last;
    assign mosi_s    = mosi_pipe[STAGES-1];
    assign cs_idle   = cs_pipe[STAGES-1];
endmodule

// File: rtl/oss_fifo.sv
// Single-clock sample FIFO with a first-word-fall-through head output.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are both dropped.
module oss_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       pop,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, push_ok, pop_ok;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = mem[rp];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R6: a push offered while full, with no pop, leaves the FIFO full.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == FULL_LVL));

    // R5: a pop on an empty FIFO, with no push, leaves it empty.
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/oss_spi_regs.sv
// Mode-0, MSB-first SPI target that works on oversampled pins. A transfer
// is a command byte, DUMMY don't-care cycles, then data. Bit 7 of the
// command selects read (1) or write (0), and bits 6:0 give the address.
// Registers 0..NUM_REGS-1 are 8-bit control registers; register 0 is the
// data_ready threshold. FIFO_ADDR returns {valid, 7'b0, sample} and pops
// the FIFO.
// Assumes DUMMY >= 1, NUM_REGS >= 2, and FIFO_ADDR >= NUM_REGS.
module oss_spi_regs
    import oss_pkg::*;
#(
    parameter int         NUM_REGS    = 4,
    parameter int         DUMMY       = 4,
    parameter int         FIFO_DEPTH  = 16,
    parameter int         SAMPLE_W    = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] FIFO_ADDR   = 7'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sclk,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic                adc_valid,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                data_ready
);
    localparam int RD_W  = SAMPLE_W + 8;
    localparam int CNT_W = $clog2(DUMMY + 8) + 1;
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic               rise, fall, mosi_s, cs_idle;
    phase_t             phase;
    logic [CNT_W-1:0]   bitcnt;
    logic [6:0]         cmd_sh, wr_sh;
    logic               is_read;
    logic [6:0]         addr;
    logic [RD_W-1:0]    rd_sh, rd_word;
    logic               miso_q;
    logic [7:0]         ctrl [NUM_REGS];
    logic               load_stb, wr_stb, fifo_pop, addr_mapped;
    logic [SAMPLE_W-1:0] f_head;
    logic [LVL_W-1:0]   f_level;
    logic               f_empty;

    oss_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_pin(spi_sclk), .mosi_pin(spi_mosi), .cs_n_pin(spi_cs_n),
        .sclk_rise(rise), .sclk_fall(fall), .mosi_s(mosi_s), .cs_idle(cs_idle)
    );

    oss_fifo #(.DW(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(adc_valid), .wdata(adc_sample), .pop(fifo_pop),
        .head(f_head), .level(f_level), .empty(f_empty)
    );

    assign addr_mapped = (int'(addr) < NUM_REGS);
    assign load_stb = rise & ~cs_idle & (phase == PH_DUMMY) & is_read &
                      (bitcnt == CNT_W'(DUMMY - 1));
    assign wr_stb   = rise & ~cs_idle & (phase == PH_DATA) & ~is_read &
                      (bitcnt == CNT_W'(7));
    assign fifo_pop = load_stb & (addr == FIFO_ADDR) & ~f_empty;

    // Select the word a read will return, at the moment the dummy phase ends.
    always_comb begin
        rd_word = '0;
        if (addr == FIFO_ADDR)
            rd_word = {~f_empty, 7'b0, {SAMPLE_W{~f_empty}} & f_head};
        else if (addr_mapped)
            rd_word = {ctrl[addr[IDX_W-1:0]], {SAMPLE_W{1'b0}}};
    end

    // Transfer sequencer: decodes the command, counts the dummy cycles and
    // shifts the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CMD;
            bitcnt  <= '0;
            cmd_sh  <= '0;
            wr_sh   <= '0;
            is_read <= 1'b0;
            addr    <= '0;
            rd_sh   <= '0;
            miso_q  <= 1'b0;
        end else if (cs_idle) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
            miso_q <= 1'b0;
        end else begin
            if (rise) begin
                case (phase)
                    PH_CMD: begin
                        cmd_sh <= {cmd_sh[5:0], mosi_s};
                        if (bitcnt == CNT_W'(7)) begin
                            is_read <= cmd_sh[6];
                            addr    <= {cmd_sh[5:0], mosi_s};
                            bitcnt  <= '0;
                            phase   <= PH_DUMMY;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    PH_DUMMY: begin
                        if (bitcnt == CNT_W'(DUMMY - 1)) begin
                            bitcnt <= '0;
                            phase  <= PH_DATA;
                            if (is_read) rd_sh <= rd_word;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        wr_sh <= {wr_sh[5:0], mosi_s};
                        if (!is_read) begin
                            if (bitcnt == CNT_W'(7)) phase <= PH_DONE;
                            else bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (fall) begin
                if (phase == PH_DATA && is_read) begin
                    miso_q <= rd_sh[RD_W-1];
                    rd_sh  <= rd_sh << 1;
                end else begin
                    miso_q <= 1'b0;
                end
            end
        end
    end

    // Control register bank: resets the threshold and stores committed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                ctrl[i] <= (i == 0) ? 8'(FIFO_DEPTH / 2) : 8'h00;
        end else if (wr_stb && addr_mapped) begin
            ctrl[addr[IDX_W-1:0]] <= {wr_sh, mosi_s};
        end
    end

    assign spi_miso   = miso_q;
    assign data_ready = (9'(f_level) >= {1'b0, ctrl[0]});

    // R8: a deselected chip select returns the sequencer to the command phase.
    a_r8_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (phase == PH_CMD && bitcnt == '0));

    // R4: a read pops at most once, so two pops never occur back to back.
    a_r4_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R9: once the pin has been high long enough to pass the synchronizer,
    // MISO is low.
    a_r9_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 3) && $past(spi_cs_n, 2)) |-> !spi_miso);
endmodule

// File: tb/tb_oss_spi_regs.sv
// Self-checking bench for oss_spi_regs with a behavioural queue/array model.
module tb_oss_spi_regs;
    localparam int DUMMY = 4;
    localparam int DEPTH = 16;
    localparam int HALF  = 5;
    localparam logic [6:0] FADDR = 7'h10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;
    logic adc_valid = 1'b0;
    logic [15:0] adc_sample = '0;
    logic data_ready;

    int checks = 0;
    int failures = 0;
    bit quiet = 1'b0;

    int        mq[$];
    logic [7:0] mreg [4];

    always #2 clk = ~clk;

    oss_spi_regs dut (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso),
        .adc_valid(adc_valid), .adc_sample(adc_sample),
        .data_ready(data_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model: a push is accepted while fewer than DEPTH entries are held (R6).
    always @(posedge clk) begin
        if (rst_n && adc_valid && mq.size() < DEPTH) mq.push_back(int'(adc_sample));
    end

    // Idle-cycle comparison of data_ready (R7) and MISO (R9).
    always @(negedge clk) begin
        if (rst_n && quiet) begin
            check("R7 data_ready", {31'b0, data_ready},
                  {31'b0, (mq.size() >= int'(mreg[0]))});
            check("R9 miso idle", {31'b0, spi_miso}, 32'h0);
        end
    end

    // One serial transfer; abort_at >= 0 raises chip select after that many bits.
    task automatic xfer(input logic [7:0] cmd, input int dbits, input logic [23:0] wdata,
                        input int abort_at, output logic [23:0] rdata);
        int total;
        total = 8 + DUMMY + dbits;
        rdata = '0;
        quiet = 1'b0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < total; i++) begin
            if (i == abort_at) break;
            if (i < 8) spi_mosi = cmd[7 - i];
            else if (i < 8 + DUMMY) spi_mosi = 1'b0;
            else spi_mosi = wdata[23 - (i - 8 - DUMMY)];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            if (i >= 8 + DUMMY) rdata = {rdata[22:0], spi_miso};
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (6) @(negedge clk);
        quiet = 1'b1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] v);
        logic [23:0] d;
        xfer({1'b0, a}, 8, {v, 16'h0}, -1, d);
        if (int'(a) < 4) mreg[a[1:0]] = v;
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] v);
        logic [23:0] d;
        xfer({1'b1, a}, 8, 24'h0, -1, d);
        v = d[7:0];
    endtask

    task automatic rd_fifo(output logic [23:0] v, output logic [23:0] exp);
        if (mq.size() > 0) exp = {8'h80, 16'(mq[0])};
        else exp = 24'h0;
        xfer({1'b1, FADDR}, 24, 24'h0, -1, v);
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    task automatic push(input logic [15:0] s);
        @(negedge clk);
        adc_valid = 1'b1;
        adc_sample = s;
        @(negedge clk);
        adc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [23:0] w, e;
        mreg[0] = 8'd8; mreg[1] = 8'h0; mreg[2] = 8'h0; mreg[3] = 8'h0;
        repeat (5) @(negedge clk);
        check("R1 miso in reset", {31'b0, spi_miso}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 data_ready after reset", {31'b0, data_ready}, 32'h0);
        quiet = 1'b1;

        rd_reg(7'd0, b); check("R1 threshold reset", {24'b0, b}, 32'h08);
        for (int i = 1; i < 4; i++) begin
            rd_reg(7'(i), b); check("R1 reg reset", {24'b0, b}, 32'h0);
        end

        wr(7'd1, 8'hA5); wr(7'd2, 8'h3C);
        rd_reg(7'd1, b); check("R2 write/read reg1", {24'b0, b}, 32'hA5);
        rd_reg(7'd2, b); check("R2 write/read reg2", {24'b0, b}, 32'h3C);
        rd_reg(7'd1, b); check("R3 repeat read unchanged", {24'b0, b}, 32'hA5);

        rd_reg(7'd5, b); check("R10 unmapped read zero", {24'b0, b}, 32'h0);
        wr(7'd5, 8'h77);
        rd_reg(7'd5, b); check("R10 unmapped write ignored", {24'b0, b}, 32'h0);
        wr(FADDR, 8'hFF);
        rd_fifo(w, e); check("R10 fifo addr write ignored", {8'b0, w}, {8'b0, e});
        check("R5 empty read zero", {8'b0, w}, 32'h0);

        push(16'h1234); push(16'hBEEF); push(16'h0F0F);
        for (int i = 0; i < 3; i++) begin
            rd_fifo(w, e); check("R4 fifo read in order", {8'b0, w}, {8'b0, e});
        end
        rd_fifo(w, e); check("R5 drained read invalid", {8'b0, w}, 32'h0);

        wr(7'd0, 8'd4);
        push(16'h0001); push(16'h0002); push(16'h0003);
        @(negedge clk); check("R7 below threshold", {31'b0, data_ready}, 32'h0);
        push(16'h0004);
        @(negedge clk); check("R7 at threshold", {31'b0, data_ready}, 32'h1);
        rd_fifo(w, e); check("R4 pop one", {8'b0, w}, {8'b0, e});
        check("R7 after pop", {31'b0, data_ready}, 32'h0);
        for (int i = 0; i < 3; i++) rd_fifo(w, e);

        for (int i = 0; i < 20; i++) push(16'(16'hA000 + i));
        check("R6 level capped", mq.size(), 32'd16);
        for (int i = 0; i < 17; i++) begin
            rd_fifo(w, e);
            check(i < 16 ? "R6 stored sample" : "R6 dropped beyond depth",
                  {8'b0, w}, i < 16 ? {8'b0, 8'h80, 16'(16'hA000 + i)} : 32'h0);
        end

        xfer({1'b0, 7'd1}, 8, {8'h11, 16'h0}, 8 + DUMMY + 4, w);
        rd_reg(7'd1, b); check("R8 aborted write not stored", {24'b0, b}, 32'hA5);
        xfer({1'b1, 7'd2}, 8, 24'h0, 3, w);
        rd_reg(7'd2, b); check("R8 read after aborted command", {24'b0, b}, 32'h3C);
        push(16'hCAFE);
        xfer({1'b1, FADDR}, 24, 24'h0, 8 + 2, w);
        rd_fifo(w, e); check("R8 aborted read did not pop", {8'b0, w}, 32'h80CAFE);

        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule